// File: doc/BRIEF.md
# NAND Ready and Status Waiter

This block ends a NAND flash program, erase or reset sequence. It holds off a fixed guard time after the operation's command so that the device's write-to-busy window is respected. Then it waits for the device to finish, using one of two methods. In pin mode it watches the ready/busy line. In status mode it issues the status command once and keeps reading the status byte until the ready bit is set. A millisecond timer bounds the wait against a limit chosen at start. In both modes the block finishes with one more status read, which it reports.

Status reads and the single command byte go through a simple byte interface. The block raises a request and holds it until the attached bus engine returns an acknowledge. On a read, the acknowledge comes with the byte. The timing of each bus cycle belongs to that engine. When the block completes, it pulses `done` and presents three results: the captured status byte, a flag saying the wait ran out of time, and a warning that the final byte still showed the device busy.

Top module: `nand_ready_waiter`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out`, `warn` and `bus_req` are low and `status` is 00h.
- R2: A `start` pulse is accepted only when `busy` is low. It latches the mode (`use_status` 1 = status polling, 0 = ready pin) and the limit. A `start` while busy has no effect.
- R3: For GUARD_CYC cycles after the start edge, with GUARD_CYC = ceil(GUARD_NS·CLK_KHZ/10^6) and at least 1, the block makes no bus request and ignores `rdy_pin`.
- R4: In pin mode the wait ends in the first cycle after the guard in which `rdy_pin` is high. Next comes exactly one command transfer (`bus_cmd` high, `bus_wdata` = 70h), then one read.
- R5: In status mode, after the guard the block sends the 70h command once. It then issues back-to-back reads with `bus_cmd` low and no further command, until a read returns bit 6 (the ready bit) set.
- R6: After the wait ends, one final read is made. `status` takes that byte with all bits unchanged, including bit 0, the fail flag. `warn` is high exactly when bit 6 of that byte is clear.
- R7: The timer advances one millisecond every CLK_KHZ cycles, starting from the start edge. The limit is reached in cycle k after the start edge when floor(k/CLK_KHZ) ≥ limit. In pin mode, if `rdy_pin` is still low in that cycle, the wait ends with `timed_out` set. If it is high in that cycle, `timed_out` stays clear.
- R8: In status mode, a poll read that is acknowledged with bit 6 clear after the limit has been reached ends the wait with `timed_out` set. A read that returns ready never sets it.
- R9: A `timeout_ms` of 0 selects the default limit: 400 ms in pin mode and 250 ms in status mode.
- R10: `done` is a one-cycle pulse, and `busy` is low in that cycle. `status`, `warn` and `timed_out` change only together with `done` and otherwise hold. A raised `bus_req` stays high until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wait |
| use_status | input | 1 | 1 = status polling, 0 = ready pin |
| timeout_ms | input | TMO_W | Limit in ms, 0 = default |
| rdy_pin | input | 1 | Ready/busy line, high = ready |
| bus_req | output | 1 | Byte transfer request |
| bus_cmd | output | 1 | Transfer is a command write |
| bus_wdata | output | 8 | Command byte |
| bus_ack | input | 1 | Transfer complete |
| bus_rdata | input | 8 | Status byte returned with ack |
| busy | output | 1 | Wait in progress |
| done | output | 1 | Completion pulse |
| timed_out | output | 1 | Last wait hit its limit |
| warn | output | 1 | Last final status showed not ready |
| status | output | 8 | Last captured status byte |

## Verification
On every cycle the assertions check the structural properties: no request in the first guard cycle, a request held until its acknowledge, the command byte value, a single-cycle `done` in an idle cycle, `warn` agreeing with bit 6 of `status`, and results that move only with `done`. Only the bench's scenarios can show the rest. That covers the exact guard length, the millisecond boundary at which pin mode does or does not time out, the single command followed by repeated polls, the default limits for a zero request, and a start during a wait being ignored. A reference model run alongside checks these cycle by cycle.

// File: rtl/nand_ready_waiter.sv
module nand_ready_waiter #(
  parameter int CLK_KHZ     = 200000,
  parameter int GUARD_NS    = 100,
  parameter int TMO_W       = 10,
  parameter int PIN_DEF_MS  = 400,
  parameter int STAT_DEF_MS = 250,
  parameter int RDY_BIT     = 6,
  parameter logic [7:0] STAT_CMD = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_status,
  input  logic [TMO_W-1:0] timeout_ms,
  input  logic             rdy_pin,
  output logic             bus_req,
  output logic             bus_cmd,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic             timed_out,
  output logic             warn,
  output logic [7:0]       status
);

  localparam longint GPROD     = longint'(GUARD_NS) * longint'(CLK_KHZ);
  localparam int     GUARD_RAW = int'((GPROD + 64'd999999) / 64'd1000000);
  localparam int     GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int     GW        = $clog2(GUARD_CYC + 1);
  localparam int     PW        = $clog2(CLK_KHZ + 1);

  typedef enum logic [2:0] {S_IDLE, S_GUARD, S_PIN, S_CMD, S_POLL, S_FINAL} st_t;

  st_t              st;
  logic [GW-1:0]    gcnt;
  logic [PW-1:0]    pcnt;
  logic [TMO_W-1:0] ms, limit;
  logic             mode, late;
  logic             expired;

  assign expired   = (ms >= limit);
  assign busy      = (st != S_IDLE);
  assign bus_req   = (st == S_CMD) || (st == S_POLL) || (st == S_FINAL);
  assign bus_cmd   = (st == S_CMD);
  assign bus_wdata = bus_cmd ? STAT_CMD : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_IDLE) begin
      pcnt <= '0;
      ms   <= '0;
    end else if (pcnt == PW'(CLK_KHZ - 1)) begin
      pcnt <= '0;
      if (ms != '1) ms <= ms + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      gcnt      <= '0;
      limit     <= '0;
      mode      <= 1'b0;
      late      <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      warn      <= 1'b0;
      status    <= 8'h00;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_GUARD;
          gcnt <= GW'(GUARD_CYC - 1);
          mode <= use_status;
          late <= 1'b0;
          if (timeout_ms == '0)
            limit <= use_status ? TMO_W'(STAT_DEF_MS) : TMO_W'(PIN_DEF_MS);
          else
            limit <= timeout_ms;
        end
        S_GUARD: begin
          if (gcnt == '0) st <= mode ? S_CMD : S_PIN;
          else            gcnt <= gcnt - 1'b1;
        end
        S_PIN: begin
          if (rdy_pin) st <= S_CMD;
          else if (expired) begin
            late <= 1'b1;
            st   <= S_CMD;
          end
        end
        S_CMD: if (bus_ack) st <= mode ? S_POLL : S_FINAL;
        S_POLL: if (bus_ack) begin
          if (bus_rdata[RDY_BIT]) st <= S_FINAL;
          else if (expired) begin
            late <= 1'b1;
            st   <= S_FINAL;
          end
        end
        S_FINAL: if (bus_ack) begin
          status    <= bus_rdata;
          warn      <= ~bus_rdata[RDY_BIT];
          timed_out <= late;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_ready_waiter_chk.sv
module nand_ready_waiter_chk #(
  parameter int RDY_BIT = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_cmd,
  input logic [7:0] bus_wdata,
  input logic       bus_ack,
  input logic       busy,
  input logic       done,
  input logic       timed_out,
  input logic       warn,
  input logic [7:0] status
);

  AST_GUARD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !bus_req); // R3
  AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n) bus_cmd |-> (bus_req && bus_wdata == 8'h70)); // R4
  AST_WARN_BIT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (warn == !status[RDY_BIT])); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_ack) |=> bus_req); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> busy); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(status) && $stable(warn) && $stable(timed_out)) |-> done); // R10

endmodule

bind nand_ready_waiter nand_ready_waiter_chk #(.RDY_BIT(RDY_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .busy(busy), .done(done),
  .timed_out(timed_out), .warn(warn), .status(status)
);

// File: tb/nand_ready_waiter_tb.sv
module nand_ready_waiter_tb;
  localparam int KHZ = 8;
  localparam int GNS = 500000;
  localparam int TW  = 10;
  localparam int GC  = 4;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, use_status = 1'b0, rdy_pin = 1'b0;
  logic [TW-1:0] timeout_ms = '0;
  logic bus_req, bus_cmd, bus_ack = 1'b0;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;
  logic busy, done, timed_out, warn;
  logic [7:0] status;

  int total = 0, bad = 0, cyc = 0, wc = 0;
  logic [7:0] q[$];
  logic [7:0] idle_byte = 8'h00;

  always #2.5 clk = ~clk;

  nand_ready_waiter #(.CLK_KHZ(KHZ), .GUARD_NS(GNS), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_status(use_status),
    .timeout_ms(timeout_ms), .rdy_pin(rdy_pin), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .timed_out(timed_out),
    .warn(warn), .status(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // byte bus responder: ack after LAT idle cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      wc = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wc == LAT) begin
        bus_ack = 1'b1;
        wc = 0;
        if (bus_cmd) bus_rdata = 8'hEE;
        else if (q.size() > 0) bus_rdata = q.pop_front();
        else bus_rdata = idle_byte;
      end else wc++;
    end
  end

  // reference model: 0 idle, 1 guard, 2 pin wait, 3 command, 4 poll, 5 final
  int m_ph = 0, m_el = 0, m_g = 0, m_lim = 0;
  bit m_mode = 0, m_late = 0, m_exp = 0, m_was = 0;
  bit e_done = 0, e_to = 0, e_warn = 0;
  logic [7:0] e_stat = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; e_done = 0; e_to = 0; e_warn = 0; e_stat = 8'h00;
    end else begin
      e_done = 0;
      m_was = (m_ph != 0);
      m_exp = (m_el / KHZ) >= m_lim;
      case (m_ph)
        0: if (start) begin
          m_ph = 1; m_g = GC; m_el = 0; m_mode = use_status; m_late = 0;
          m_lim = (timeout_ms == 0) ? (use_status ? 250 : 400) : int'(timeout_ms);
        end
        1: begin m_g--; if (m_g == 0) m_ph = m_mode ? 3 : 2; end
        2: if (rdy_pin) m_ph = 3; else if (m_exp) begin m_late = 1; m_ph = 3; end
        3: if (bus_ack) m_ph = m_mode ? 4 : 5;
        4: if (bus_ack) begin
          if (bus_rdata[6]) m_ph = 5;
          else if (m_exp) begin m_late = 1; m_ph = 5; end
        end
        5: if (bus_ack) begin
          e_stat = bus_rdata; e_warn = !bus_rdata[6]; e_to = m_late; e_done = 1; m_ph = 0;
        end
        default: m_ph = 0;
      endcase
      if (m_was) m_el++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", busy, m_ph != 0);
      check("R3 bus_req", bus_req, m_ph >= 3);
      check("R5 bus_cmd", bus_cmd, m_ph == 3);
      if (bus_req) check("R4 bus_wdata", bus_wdata, (m_ph == 3) ? 8'h70 : 8'h00);
      check("R10 done", done, e_done);
      check("R6 status", status, e_stat);
      check("R6 warn", warn, e_warn);
      check("R7 timed_out", timed_out, e_to);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int elapsed;
  task automatic go(input bit mode, input int tmo);
    @(negedge clk);
    start = 1'b1; use_status = mode; timeout_ms = TW'(tmo);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    elapsed = 0;
    while (!done && elapsed < 5000) begin @(negedge clk); elapsed++; end
    check("R10 done seen", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0); check("R1 bus_req", bus_req, 0);
    check("R1 done", done, 0); check("R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: ready already high, ignored during guard
    rdy_pin = 1'b1; q = {8'h40};
    go(0, 5); wait_done();
    check("R4 no timeout", timed_out, 0); check("R6 status", status, 8'h40);
    rdy_pin = 1'b0;

    // R4 pin wait with fail bit passthrough
    q = {8'h41};
    go(0, 5); repeat (20) @(negedge clk); rdy_pin = 1'b1;
    wait_done();
    check("R6 fail bit", status, 8'h41); check("R6 warn", warn, 0);
    rdy_pin = 1'b0;

    // R7 pin timeout
    q = {8'h00};
    go(0, 3); wait_done();
    check("R7 timed_out", timed_out, 1); check("R6 warn", warn, 1);

    // R7 boundary: ready in the expiry cycle
    q = {8'h40};
    go(0, 3); repeat (3 * KHZ) @(negedge clk); rdy_pin = 1'b1;
    wait_done();
    check("R7 boundary ready", timed_out, 0);
    rdy_pin = 1'b0;
    q = {8'h40};
    go(0, 3); repeat (3 * KHZ + 1) @(negedge clk); rdy_pin = 1'b1;
    wait_done();
    check("R7 one late", timed_out, 1);
    rdy_pin = 1'b0;

    // R5 status polling
    q = {8'h00, 8'h01, 8'h40, 8'h41};
    go(1, 20); wait_done();
    check("R5 no timeout", timed_out, 0); check("R5 status", status, 8'h41);

    // R8 status timeout, R2 start while busy ignored
    q.delete(); idle_byte = 8'h00;
    go(1, 2); start = 1'b1; use_status = 1'b0; @(negedge clk); start = 1'b0;
    wait_done();
    check("R8 timed_out", timed_out, 1); check("R8 warn", warn, 1);

    // R9 defaults
    go(1, 0); wait_done();
    check("R9 status default", timed_out, 1);
    check("R9 250ms elapsed", elapsed >= 250 * KHZ, 1);
    idle_byte = 8'h40;
    go(0, 0); wait_done();
    check("R9 pin default", timed_out, 1);
    check("R9 400ms elapsed", elapsed >= 400 * KHZ, 1);
    check("R9 warn", warn, 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule